// File: doc/BRIEF.md
# Block Transfer and Search Sequencer

This block runs string operations one element at a time, driving a byte-wide memory port and a byte-wide I/O port through a ready handshake. It holds three 16-bit working registers: a source pointer (`hl`), a destination pointer (`de`) and a count or port register (`bc`, with `b` as its upper byte and `c` as its lower byte). It also holds an 8-bit accumulator, which is used only for search comparisons, and an 8-bit flag register.

The host loads all of these registers and a command on a one-cycle `start_i` pulse. The command gives the operation, the step direction, single or repeat mode, exact flag mode, and the incrementing-port variant of output. The block then performs memory and I/O accesses until the command ends. When it ends, it raises `done_o` for one cycle, and the final register and flag values are visible at the same time.

The four operations are:
- Copy: a byte goes from memory at `hl` to memory at `de`.
- Search: the byte at memory `hl` is compared against the accumulator.
- Input: a byte goes from I/O port `bc` to memory at `hl`.
- Output: a byte goes from memory at `hl` to I/O port `bc`, or to port `c` alone in the incrementing-port variant.

Top module: `blk_seq`

## Requirements
- R1: A copy element reads memory at `hl`, then writes that byte to memory at `de`. It then steps `hl` and `de` by one, up when `cmd_dec_i`=0 and down when it is 1, and decrements `bc` by one.
- R2: The flag byte uses these bits: bit 7 S, bit 6 Z, bit 5 Y, bit 4 H, bit 3 X, bit 2 PV, bit 1 N, bit 0 C. After a copy element, H and N are 0 and PV is 1 exactly when the new `bc` is nonzero. S, Z and C keep their values. With `cmd_exact_i`=0, Y and X also keep their values.
- R3: With `cmd_exact_i`=1, a copy element sets Y to bit 1 and X to bit 3 of (accumulator + moved byte), taken modulo 256.
- R4: A search element reads memory at `hl` and performs no write. It forms r = accumulator − byte. The flags become: S = r[7]; Z = (r==0); H = borrow out of the low nibble; N = 1; C unchanged; PV = (new `bc` != 0). Then `hl` steps and `bc` decrements. In non-exact mode Y = r[5] and X = r[3]. In exact mode, Y and X are bits 1 and 3 of r − H.
- R5: A repeated copy keeps running until `bc` reaches zero. A start value of zero therefore gives 65536 elements.
- R6: A repeated search stops after the first element that either sets Z or brings `bc` to zero.
- R7: An input element reads I/O port `bc`, then writes the byte to memory at `hl`. It steps `hl`, decrements `b` and leaves `c` unchanged. It sets N = 1 and Z = (new `b` == 0), and keeps all other flags.
- R8: An output element reads memory at `hl`, then writes the byte to I/O port `bc`. Its register and flag updates are the same as for input.
- R9: With `cmd_portinc_i`=1 on output, the port address is {8'h00, `c`}, and `c` steps in the same direction as `hl`.
- R10: A repeated input or output keeps running while the new `b` is nonzero. A start value of `b` = 0 gives 256 elements.
- R11: A strobe stays high with a stable address until its ready input is 1. No register changes before that.
- R12: `done_o` is high for exactly one cycle, after the last element, with `busy_o` low. At that time the outputs show the final values.
- R13: While reset is active, all registers read zero and all strobes, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads registers and command when idle |
| cmd_op_i | input | 2 | 0 copy, 1 search, 2 input, 3 output |
| cmd_dec_i | input | 1 | Step pointers downward |
| cmd_rep_i | input | 1 | Repeat until termination condition |
| cmd_exact_i | input | 1 | Exact Y/X flag mode |
| cmd_portinc_i | input | 1 | Output to port `c` with stepping `c` |
| hl_i | input | 16 | Start source pointer |
| de_i | input | 16 | Start destination pointer |
| bc_i | input | 16 | Start count / port |
| acc_i | input | 8 | Accumulator |
| flags_i | input | 8 | Start flags |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |
| mem_rdy_i | input | 1 | Memory access complete |
| io_addr_o | output | 16 | I/O port address |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| io_wdata_o | output | 8 | I/O write data |
| io_rdata_i | input | 8 | I/O read data |
| io_rdy_i | input | 1 | I/O access complete |
| hl_o | output | 16 | Current source pointer |
| de_o | output | 16 | Current destination pointer |
| bc_o | output | 16 | Current count / port |
| flags_o | output | 8 | Current flags |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |

## Verification
Copy is run in several forms:
- Single steps with all flags set and with all flags clear. These separate the preserved flags from the forced flags, and the PV result at `bc` = 1 from the PV result at other counts.
- An exact-mode step whose sum has only bit 3 set. This shows where Y and X are taken from.
- A descending repeat. This checks both the direction of stepping and the termination.
- A repeat starting at zero count. This must produce exactly 65536 writes.

Search is run three ways: once as a single mismatch, once as a repeat that hits a match in the middle of the buffer, and once as a repeat that runs out of count. Together these separate the two stop conditions.

I/O is run as a single input, a two-element repeated input, a 256-element output starting from `b` = 0, and an incrementing-port output. The port addresses logged during the incrementing-port output show whether `c` or `bc` drives the port.

A held-off memory ready shows that the strobe, the address and the registers all freeze during a wait.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
  typedef enum logic [1:0] {OP_COPY = 2'd0, OP_CMP = 2'd1, OP_IN = 2'd2, OP_OUT = 2'd3} op_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} st_e;
  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_X  = 3;
  localparam int F_H  = 4;
  localparam int F_Y  = 5;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;
endpackage

// File: rtl/blk_seq_step.sv
module blk_seq_step
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  op_e               op_i,
  input  logic              dec_i,
  input  logic              pinc_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] de_i,
  input  logic [ADDR_W-1:0] bc_i,
  output logic [ADDR_W-1:0] hl_n_o,
  output logic [ADDR_W-1:0] de_n_o,
  output logic [ADDR_W-1:0] bc_n_o,
  output logic              bc_zero_o,
  output logic              b_zero_o
);
  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] stp;
  logic [HALF_W-1:0] b_cur, c_cur, b_dec, c_nxt;
  logic              is_io;

  always_comb begin
    stp    = dec_i ? '1 : ADDR_W'(1);
    is_io  = (op_i == OP_IN) || (op_i == OP_OUT);
    b_cur  = bc_i[ADDR_W-1:HALF_W];
    c_cur  = bc_i[HALF_W-1:0];
    b_dec  = b_cur - HALF_W'(1);
    // incrementing-port output: port byte walks with the pointer
    c_nxt  = (op_i == OP_OUT && pinc_i) ? c_cur + stp[HALF_W-1:0] : c_cur;
    hl_n_o = hl_i + stp;
    de_n_o = (op_i == OP_COPY) ? de_i + stp : de_i;
    bc_n_o = is_io ? {b_dec, c_nxt} : bc_i - ADDR_W'(1);
    bc_zero_o = (bc_n_o == '0);
    b_zero_o  = (bc_n_o[ADDR_W-1:HALF_W] == '0);
  end
endmodule

// File: rtl/blk_seq_flags.sv
module blk_seq_flags
  import blk_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic              exact_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] dat_i,
  input  logic [7:0]        flags_i,
  input  logic              bc_zero_i,
  input  logic              b_zero_i,
  output logic [7:0]        flags_n_o,
  output logic              more_o
);
  localparam int HBIT = DATA_W / 2;

  logic [DATA_W-1:0] sum, diff, adj;
  logic              half, hit;

  always_comb begin
    sum  = acc_i + dat_i;
    diff = acc_i - dat_i;
    half = acc_i[HBIT] ^ dat_i[HBIT] ^ diff[HBIT];
    adj  = diff - DATA_W'(half);
    hit  = (diff == '0);
    flags_n_o = flags_i;
    more_o    = 1'b0;
    unique case (op_i)
      OP_COPY: begin
        flags_n_o[F_H]  = 1'b0;
        flags_n_o[F_N]  = 1'b0;
        flags_n_o[F_PV] = !bc_zero_i;
        if (exact_i) begin
          flags_n_o[F_Y] = sum[1];
          flags_n_o[F_X] = sum[3];
        end
        more_o = !bc_zero_i;
      end
      OP_CMP: begin
        flags_n_o[F_S]  = diff[DATA_W-1];
        flags_n_o[F_Z]  = hit;
        flags_n_o[F_H]  = half;
        flags_n_o[F_N]  = 1'b1;
        flags_n_o[F_PV] = !bc_zero_i;
        flags_n_o[F_Y]  = exact_i ? adj[1] : diff[5];
        flags_n_o[F_X]  = exact_i ? adj[3] : diff[3];
        more_o = !bc_zero_i && !hit;
      end
      default: begin
        flags_n_o[F_Z] = b_zero_i;
        flags_n_o[F_N] = 1'b1;
        more_o = !b_zero_i;
      end
    endcase
  end
endmodule

// File: rtl/blk_seq_ctrl.sv
module blk_seq_ctrl
  import blk_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  op_e  op_i,
  input  logic rep_i,
  input  logic more_i,
  input  logic mem_rdy_i,
  input  logic io_rdy_i,
  output st_e  st_o,
  output logic load_o,
  output logic cap_o,
  output logic upd_o,
  output logic done_o
);
  st_e  st_q, st_d;
  logic rdy, cont, done_q;

  always_comb begin
    if (st_q == ST_RD) rdy = (op_i == OP_IN)  ? io_rdy_i : mem_rdy_i;
    else               rdy = (op_i == OP_OUT) ? io_rdy_i : mem_rdy_i;
    load_o = (st_q == ST_IDLE) && start_i;
    cap_o  = (st_q == ST_RD) && rdy && (op_i != OP_CMP);
    upd_o  = rdy && (((st_q == ST_RD) && (op_i == OP_CMP)) || (st_q == ST_WR));
    cont   = rep_i && more_i;
    st_d   = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) st_d = ST_RD;
      ST_RD:   if (cap_o)   st_d = ST_WR;
      default: ;
    endcase
    if (upd_o) st_d = cont ? ST_RD : ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= upd_o && !cont;
    end
  end

  assign st_o   = st_q;
  assign done_o = done_q;

  AST_NO_UPD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !upd_o);  // R11
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (st_q == ST_RD));  // R11
endmodule

// File: rtl/blk_seq.sv
module blk_seq
  import blk_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_dec_i,
  input  logic              cmd_rep_i,
  input  logic              cmd_exact_i,
  input  logic              cmd_portinc_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] de_i,
  input  logic [ADDR_W-1:0] bc_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [7:0]        flags_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic [DATA_W-1:0] io_wdata_o,
  input  logic [DATA_W-1:0] io_rdata_i,
  input  logic              io_rdy_i,
  output logic [ADDR_W-1:0] hl_o,
  output logic [ADDR_W-1:0] de_o,
  output logic [ADDR_W-1:0] bc_o,
  output logic [7:0]        flags_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int HALF_W = ADDR_W / 2;

  op_e               op_q;
  logic              dec_q, rep_q, exact_q, pinc_q;
  logic [ADDR_W-1:0] hl_q, de_q, bc_q;
  logic [DATA_W-1:0] acc_q, dat_q, dat_use, rd_data;
  logic [7:0]        flg_q, flg_n;
  logic [ADDR_W-1:0] hl_n, de_n, bc_n;
  logic              bc_zero, b_zero, more;
  st_e               st;
  logic              load, cap, upd;

  blk_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .op_i(op_q), .rep_i(rep_q), .more_i(more),
    .mem_rdy_i, .io_rdy_i,
    .st_o(st), .load_o(load), .cap_o(cap), .upd_o(upd), .done_o(done_o)
  );

  blk_seq_step #(.ADDR_W(ADDR_W)) u_step (
    .op_i(op_q), .dec_i(dec_q), .pinc_i(pinc_q),
    .hl_i(hl_q), .de_i(de_q), .bc_i(bc_q),
    .hl_n_o(hl_n), .de_n_o(de_n), .bc_n_o(bc_n),
    .bc_zero_o(bc_zero), .b_zero_o(b_zero)
  );

  blk_seq_flags #(.DATA_W(DATA_W)) u_flags (
    .op_i(op_q), .exact_i(exact_q), .acc_i(acc_q), .dat_i(dat_use),
    .flags_i(flg_q), .bc_zero_i(bc_zero), .b_zero_i(b_zero),
    .flags_n_o(flg_n), .more_o(more)
  );

  // search consumes the read byte in the same cycle it arrives
  assign rd_data = (op_q == OP_IN) ? io_rdata_i : mem_rdata_i;
  assign dat_use = (op_q == OP_CMP) ? mem_rdata_i : dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_COPY;
      dec_q   <= 1'b0;
      rep_q   <= 1'b0;
      exact_q <= 1'b0;
      pinc_q  <= 1'b0;
      hl_q    <= '0;
      de_q    <= '0;
      bc_q    <= '0;
      acc_q   <= '0;
      flg_q   <= '0;
      dat_q   <= '0;
    end else if (load) begin
      op_q    <= op_e'(cmd_op_i);
      dec_q   <= cmd_dec_i;
      rep_q   <= cmd_rep_i;
      exact_q <= cmd_exact_i;
      pinc_q  <= cmd_portinc_i;
      hl_q    <= hl_i;
      de_q    <= de_i;
      bc_q    <= bc_i;
      acc_q   <= acc_i;
      flg_q   <= flags_i;
    end else begin
      if (cap) dat_q <= rd_data;
      if (upd) begin
        hl_q  <= hl_n;
        de_q  <= de_n;
        bc_q  <= bc_n;
        flg_q <= flg_n;
      end
    end
  end

  always_comb begin
    mem_rd_o    = (st == ST_RD) && (op_q != OP_IN);
    io_rd_o     = (st == ST_RD) && (op_q == OP_IN);
    mem_wr_o    = (st == ST_WR) && (op_q != OP_OUT);
    io_wr_o     = (st == ST_WR) && (op_q == OP_OUT);
    mem_addr_o  = (st == ST_WR && op_q == OP_COPY) ? de_q : hl_q;
    io_addr_o   = (op_q == OP_OUT && pinc_q) ? {{HALF_W{1'b0}}, bc_q[HALF_W-1:0]} : bc_q;
    mem_wdata_o = dat_q;
    io_wdata_o  = dat_q;
  end

  assign hl_o    = hl_q;
  assign de_o    = de_q;
  assign bc_o    = bc_q;
  assign flags_o = flg_q;
  assign busy_o  = (st != ST_IDLE);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}));  // R11
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_rdy_i) |=> (mem_rd_o && $stable(mem_addr_o)));  // R11
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !upd) |=> ($stable(hl_o) && $stable(bc_o) && $stable(de_o)));  // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R12
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R12
  AST_COPY_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_q == OP_COPY) |=> (bc_o == $past(bc_o) - ADDR_W'(1)));  // R1
  AST_CMP_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_CMP) |-> (!mem_wr_o && !io_wr_o));  // R4
  AST_CMP_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_q == OP_CMP) |=> flags_o[F_N]);  // R4
  AST_IO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && (op_q == OP_IN || op_q == OP_OUT)) |=>
      (flags_o[F_Z] == (bc_o[ADDR_W-1:HALF_W] == '0)));  // R7
  AST_PORT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd && op_q == OP_OUT && pinc_q && !dec_q) |=>
      (bc_o[HALF_W-1:0] == $past(bc_o[HALF_W-1:0]) + HALF_W'(1)));  // R9
endmodule

// File: tb/blk_seq_tb_top.sv
module blk_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic        cmd_dec_i = 0, cmd_rep_i = 0, cmd_exact_i = 0, cmd_portinc_i = 0;
  logic [15:0] hl_i = '0, de_i = '0, bc_i = '0;
  logic [7:0]  acc_i = '0, flags_i = '0;
  logic [15:0] mem_addr_o, io_addr_o, hl_o, de_o, bc_o;
  logic        mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, busy_o, done_o;
  logic [7:0]  mem_wdata_o, io_wdata_o, mem_rdata_i, io_rdata_i, flags_o;
  logic        mem_rdy_i = 1'b1, io_rdy_i = 1'b1;

  logic [7:0]  mem [256];
  int          n_chk = 0, n_err = 0;
  int          mem_wr_cnt = 0, io_wr_cnt = 0, cyc = 0;
  logic [15:0] io_alog [8];
  logic [7:0]  io_dlog [8];

  always #2.5 clk_i = ~clk_i;

  blk_seq dut_i (.*);

  function automatic logic [7:0] io_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign mem_rdata_i = mem[mem_addr_o[7:0]];
  assign io_rdata_i  = io_val(io_addr_o);

  always @(posedge clk_i) begin
    cyc++;
    if (mem_wr_o && mem_rdy_i) begin
      mem[mem_addr_o[7:0]] <= mem_wdata_o;
      mem_wr_cnt++;
    end
    if (io_wr_o && io_rdy_i) begin
      io_alog[io_wr_cnt[2:0]] <= io_addr_o;
      io_dlog[io_wr_cnt[2:0]] <= io_wdata_o;
      io_wr_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mem_fill();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
  endtask

  // expected flags, written from the requirement text
  function automatic logic [7:0] x_copy(input logic [7:0] f, input logic [15:0] bcn,
                                        input logic ex, input logic [7:0] a, d);
    logic [7:0] r, s;
    r = f & 8'hED;
    if (bcn != 0) r |= 8'h04;
    if (ex) begin
      s = a + d;
      r = (r & 8'hD7) | {2'b0, s[1], 1'b0, s[3], 3'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] x_cmp(input logic [7:0] f, input logic [15:0] bcn,
                                       input logic [7:0] a, d);
    logic [7:0] r, res;
    res = a - d;
    r = {res[7], res == 0, res[5], a[3:0] < d[3:0], res[3], bcn != 0, 1'b1, f[0]};
    return r;
  endfunction

  task automatic launch(input logic [1:0] op, input logic dec, rep, ex, pinc,
                        input logic [15:0] hl, de, bc, input logic [7:0] a, f);
    int n;
    @(negedge clk_i);
    cmd_op_i = op; cmd_dec_i = dec; cmd_rep_i = rep; cmd_exact_i = ex; cmd_portinc_i = pinc;
    hl_i = hl; de_i = de; bc_i = bc; acc_i = a; flags_i = f; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o && n < 150000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic chk_done_pulse();
    chk("R12 done high", {31'b0, done_o}, 32'd1);
    chk("R12 busy low at done", {31'b0, busy_o}, 32'd0);
    @(negedge clk_i);
    chk("R12 done one cycle", {31'b0, done_o}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R13 hl reset", {16'b0, hl_o}, 32'd0);
    chk("R13 bc reset", {16'b0, bc_o}, 32'd0);
    chk("R13 flags reset", {24'b0, flags_o}, 32'd0);
    chk("R13 strobes", {28'b0, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}, 32'd0);
    chk("R13 busy/done", {30'b0, busy_o, done_o}, 32'd0);
  endtask

  task automatic t_copy_single();
    logic [7:0] src;
    int w0;
    mem_fill(); src = mem[8'h10]; w0 = mem_wr_cnt;
    launch(2'd0, 0, 0, 0, 0, 16'h0010, 16'h0080, 16'h0003, 8'h00, 8'hC1);
    chk("R1 copied byte", {24'b0, mem[8'h80]}, {24'b0, src});
    chk("R1 hl", {16'b0, hl_o}, 32'h0011);
    chk("R1 de", {16'b0, de_o}, 32'h0081);
    chk("R1 bc", {16'b0, bc_o}, 32'h0002);
    chk("R1 one write", mem_wr_cnt - w0, 1);
    chk("R2 flags pv set", {24'b0, flags_o}, {24'b0, x_copy(8'hC1, 16'h2, 0, 0, 0)});
    chk_done_pulse();
    launch(2'd0, 0, 0, 0, 0, 16'h0020, 16'h0040, 16'h0001, 8'h00, 8'hFF);
    chk("R2 flags pv clear, y/x kept", {24'b0, flags_o}, 32'h000000E9);
  endtask

  task automatic t_copy_exact();
    mem_fill(); mem[8'h44] = 8'h03;
    launch(2'd0, 0, 0, 1, 0, 16'h0044, 16'h0070, 16'h0002, 8'h05, 8'h00);
    chk("R3 exact y/x", {24'b0, flags_o}, 32'h0000000C);
    chk("R3 exact y/x fn", {24'b0, flags_o}, {24'b0, x_copy(8'h00, 16'h1, 1, 8'h05, 8'h03)});
  endtask

  task automatic t_copy_dec_rep();
    logic [7:0] s0, s3;
    int w0;
    mem_fill(); s0 = mem[8'h30]; s3 = mem[8'h2D]; w0 = mem_wr_cnt;
    launch(2'd0, 1, 1, 0, 0, 16'h0030, 16'h0060, 16'h0004, 8'h00, 8'h00);
    chk("R5 writes", mem_wr_cnt - w0, 4);
    chk("R5 hl", {16'b0, hl_o}, 32'h002C);
    chk("R5 de", {16'b0, de_o}, 32'h005C);
    chk("R5 bc", {16'b0, bc_o}, 32'h0);
    chk("R5 first byte", {24'b0, mem[8'h60]}, {24'b0, s0});
    chk("R5 last byte", {24'b0, mem[8'h5D]}, {24'b0, s3});
    chk("R5 pv clear", {31'b0, flags_o[2]}, 32'd0);
  endtask

  task automatic t_copy_full();
    int w0;
    mem_fill(); w0 = mem_wr_cnt;
    launch(2'd0, 0, 1, 0, 0, 16'h1000, 16'h2000, 16'h0000, 8'h00, 8'h00);
    chk("R5 65536 writes", mem_wr_cnt - w0, 65536);
    chk("R5 hl wrap", {16'b0, hl_o}, 32'h1000);
    chk("R5 bc end", {16'b0, bc_o}, 32'h0);
  endtask

  task automatic t_cmp();
    logic [7:0] d;
    int w0;
    mem_fill(); mem[8'h50] = 8'h41; d = 8'h41; w0 = mem_wr_cnt;
    launch(2'd1, 0, 0, 0, 0, 16'h0050, 16'h0000, 16'h0005, 8'h40, 8'h01);
    chk("R4 flags", {24'b0, flags_o}, {24'b0, x_cmp(8'h01, 16'h4, 8'h40, d)});
    chk("R4 flags value", {24'b0, flags_o}, 32'h000000BF);
    chk("R4 hl", {16'b0, hl_o}, 32'h0051);
    chk("R4 bc", {16'b0, bc_o}, 32'h0004);
    chk("R4 no write", mem_wr_cnt - w0, 0);
    mem[8'h50] = 8'h00; mem[8'h51] = 8'h01; mem[8'h52] = 8'h99; mem[8'h53] = 8'h99;
    launch(2'd1, 0, 1, 0, 0, 16'h0050, 16'h0000, 16'h000A, 8'h99, 8'h00);
    chk("R6 stop on match hl", {16'b0, hl_o}, 32'h0053);
    chk("R6 stop on match bc", {16'b0, bc_o}, 32'h0007);
    chk("R6 z/pv", {30'b0, flags_o[6], flags_o[2]}, 32'd3);
    mem[8'h60] = 8'h01; mem[8'h61] = 8'h02; mem[8'h62] = 8'h03;
    launch(2'd1, 0, 1, 0, 0, 16'h0060, 16'h0000, 16'h0003, 8'hEE, 8'h00);
    chk("R6 stop on count hl", {16'b0, hl_o}, 32'h0063);
    chk("R6 z/pv clear", {30'b0, flags_o[6], flags_o[2]}, 32'd0);
  endtask

  task automatic t_input();
    mem_fill();
    launch(2'd2, 0, 0, 0, 0, 16'h0090, 16'h0000, 16'h0242, 8'h00, 8'hA5);
    chk("R7 byte", {24'b0, mem[8'h90]}, {24'b0, io_val(16'h0242)});
    chk("R7 hl", {16'b0, hl_o}, 32'h0091);
    chk("R7 bc", {16'b0, bc_o}, 32'h0142);
    chk("R7 flags", {24'b0, flags_o}, 32'h000000A7);
    launch(2'd2, 1, 1, 0, 0, 16'h00A0, 16'h0000, 16'h0242, 8'h00, 8'h00);
    chk("R10 in rep bc", {16'b0, bc_o}, 32'h0042);
    chk("R10 in rep hl", {16'b0, hl_o}, 32'h009E);
    chk("R10 second byte", {24'b0, mem[8'h9F]}, {24'b0, io_val(16'h0142)});
    chk("R10 z/n", {30'b0, flags_o[6], flags_o[1]}, 32'd3);
  endtask

  task automatic t_output();
    int i0;
    mem_fill(); i0 = io_wr_cnt;
    launch(2'd3, 0, 1, 0, 0, 16'h0100, 16'h0000, 16'h00C5, 8'h00, 8'h00);
    chk("R10 256 writes", io_wr_cnt - i0, 256);
    chk("R10 hl", {16'b0, hl_o}, 32'h0200);
    chk("R10 bc", {16'b0, bc_o}, 32'h00C5);
    chk("R8 port addr", {16'b0, io_alog[(io_wr_cnt - 1) & 7]}, 32'h01C5);
    mem_fill(); i0 = io_wr_cnt;
    launch(2'd3, 0, 1, 0, 1, 16'h0020, 16'h0000, 16'h0310, 8'h00, 8'h00);
    chk("R9 writes", io_wr_cnt - i0, 3);
    chk("R9 port 0", {16'b0, io_alog[i0 & 7]}, 32'h0010);
    chk("R9 port 2", {16'b0, io_alog[(i0 + 2) & 7]}, 32'h0012);
    chk("R9 data 2", {24'b0, io_dlog[(i0 + 2) & 7]}, {24'b0, mem[8'h22]});
    chk("R9 bc", {16'b0, bc_o}, 32'h0013);
  endtask

  task automatic t_handshake();
    mem_fill();
    @(negedge clk_i);
    mem_rdy_i = 1'b0;
    cmd_op_i = 2'd0; cmd_dec_i = 0; cmd_rep_i = 0; cmd_exact_i = 0; cmd_portinc_i = 0;
    hl_i = 16'h0033; de_i = 16'h0077; bc_i = 16'h0009; acc_i = 0; flags_i = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R11 rd held", {31'b0, mem_rd_o}, 32'd1);
    chk("R11 addr held", {16'b0, mem_addr_o}, 32'h0033);
    chk("R11 hl frozen", {16'b0, hl_o}, 32'h0033);
    chk("R11 no done", {31'b0, done_o}, 32'd0);
    mem_rdy_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R11 hl after", {16'b0, hl_o}, 32'h0034);
    chk("R11 bc after", {16'b0, bc_o}, 32'h0008);
  endtask

  initial begin
    while (cyc < 199000) @(negedge clk_i);
    n_err++;
    $display("FAIL watchdog actual=%0d expected<199000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    mem_fill();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_copy_single();
    t_copy_exact();
    t_copy_dec_rep();
    t_cmp();
    t_input();
    t_output();
    t_handshake();
    t_copy_full();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule